// File: doc/BRIEF.md
# Floppy Data Rate Select Register

This block is the host-writable rate and precompensation control register of a floppy disk controller. One byte holds a two-bit rate select, a three-bit write precompensation code, a manual low-power request and a software reset request. The stored rate select and a separate two-bit drive-type input are decoded into a bit-rate code for each recording mode and a density level for the drive. The stored precompensation code is presented as it is for the write path.

Writing the low-power bit stops the controller clock through a clock-gate enable. Any of three events wakes it: a software reset, a strobe marking an access to the data register, or a strobe marking an access to the main status register. The software reset bit produces a controller reset pulse and then clears itself. A read-only copy of the last byte written can be read at offset 0x1F of a separate runtime register window.

Top module: `fdc_rate_top`

## Requirements
- R1: After hardware reset (`rstN` low), the register reads 0x02, which is select 10, precomp 000, low power 0 and reset bit 0. In this state `clkEnable` is 1, `ctlResetPulse` is 0 and `mfmRate` is code 3 (250K).
- R2: A write (`wrEn` high for one cycle) stores `wrData[1:0]` as the rate select and `wrData[4:2]` as the precomp code. From the next cycle, `precompSel` and `regRdData` reflect the new values.
- R3: Bit 5 of `regRdData` and of the shadow copy always reads 0, whatever value is written.
- R4: A write with bit 6 = 1 and bit 7 = 0 enters low power. From the next cycle `clkEnable` is 0 and `regRdData[6]` is 1.
- R5: While in low power, a cycle with `dataAccess` or `statusAccess` high leaves low power, so `clkEnable` is 1 from the next cycle. If that cycle also carries a write with bit 6 = 1, the write takes priority and low power is kept.
- R6: A write with bit 7 = 1 drives `ctlResetPulse` high for exactly the next cycle, with `regRdData[7]` reading 1 in that cycle and 0 afterwards. The same write clears low power, even if bit 6 is also 1.
- R7: Rate codes are 0 = none, 1 = 125K, 2 = 150K, 3 = 250K, 4 = 300K, 5 = 500K, 6 = 1M and 7 = 2M. With drive type 00, or 11 (which behaves as 00), the selects 11, 00, 01 and 10 give `mfmRate` 1M, 500K, 300K and 250K, and `fmRate` none, 250K, 150K and 125K.
- R8: With drive type 01, select 01 gives MFM 500K and FM 250K. With drive type 10, select 01 gives MFM 2M and FM none. For both types, selects 11, 00 and 10 decode as they do for type 00.
- R9: `densel` is 1 when the stored select is 11 or 00, and 0 when it is 01 or 10.
- R10: `rtData` returns the shadow copy when `rtAddr` is 0x1F, and 0 at every other address. The shadow copy is the last byte written, with bit 5 forced to 0 and bit 7 kept as written (it does not clear itself). After hardware reset the shadow copy is 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| dataAccess | input | 1 | Access to the data register this cycle |
| statusAccess | input | 1 | Access to the main status register this cycle |
| driveType | input | 2 | Drive-type field used by the rate decode |
| rtAddr | input | 5 | Runtime register window read address |
| rtData | output | 8 | Runtime register window read data |
| mfmRate | output | 3 | Decoded MFM bit-rate code |
| fmRate | output | 3 | Decoded FM bit-rate code |
| densel | output | 1 | Density level to the drive |
| precompSel | output | 3 | Write precompensation code |
| clkEnable | output | 1 | Controller clock-gate enable, 0 in low power |
| ctlResetPulse | output | 1 | One-cycle controller reset pulse |

## Verification
The bench measures the software reset pulse cycle by cycle. A design that held the bit, or cleared it a cycle early, would produce a pulse that is too long or missing, and bit 7 would read back wrongly. It then sets a write that enters low power against an access strobe in the same cycle; a design with the priority reversed would wake when it should stay asleep. It also checks the drive-type-dependent select 01 across all four drive types, including 11 aliased to 00, because a decode error there shows up as a wrong rate code while the other selects still decode correctly. Finally it writes 1 to bit 5 and reads back the shadow copy to catch a design that drops the mask, or that lets bit 7 of the shadow clear itself.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_LO = 0;
  localparam int PC_LO = 2;
  localparam int PC_W = 3;
  localparam int ZERO_BIT = 5;
  localparam int LP_BIT = 6;
  localparam int SWR_BIT = 7;

  typedef enum logic [2:0] {
    RATE_NONE = 3'd0,
    RATE_125K = 3'd1,
    RATE_150K = 3'd2,
    RATE_250K = 3'd3,
    RATE_300K = 3'd4,
    RATE_500K = 3'd5,
    RATE_1M   = 3'd6,
    RATE_2M   = 3'd7
  } rate_e;

  typedef struct packed {
    logic load;
    logic enterLp;
    logic exitLp;
    logic swReset;
  } ctl_strobe_t;
endpackage

// File: rtl/fdc_rate_ctrl.sv
module fdc_rate_ctrl
  import fdc_rate_pkg::*;
(
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataAccess,
  input  logic              statusAccess,
  input  logic              lowPowerQ,
  output ctl_strobe_t       strobe
);
  always_comb begin
    strobe.load    = wrEn;
    strobe.swReset = wrEn && wrData[SWR_BIT];
    // a write entering low power outranks a wake-up access in the same cycle
    strobe.enterLp = wrEn && wrData[LP_BIT] && !wrData[SWR_BIT];
    strobe.exitLp  = strobe.swReset || (lowPowerQ && (dataAccess || statusAccess));
  end
endmodule

// File: rtl/fdc_rate_dp.sv
module fdc_rate_dp
  import fdc_rate_pkg::*;
#(
  parameter int RT_ADDR_W = 5,
  parameter logic [RT_ADDR_W-1:0] SHADOW_OFS = 5'h1F,
  parameter logic [1:0] RESET_SEL = 2'b10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [1:0]           driveType,
  input  logic [RT_ADDR_W-1:0] rtAddr,
  output logic                 lowPowerQ,
  output logic [DATA_W-1:0]    regRdData,
  output logic [DATA_W-1:0]    rtData,
  output logic [2:0]           mfmRate,
  output logic [2:0]           fmRate,
  output logic                 densel,
  output logic [PC_W-1:0]      precompSel,
  output logic                 clkEnable,
  output logic                 ctlResetPulse
);
  localparam logic [DATA_W-1:0] ZERO_MASK = ~(DATA_W'(1) << ZERO_BIT);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(RESET_SEL);

  logic [1:0]        selQ;
  logic [PC_W-1:0]   pcQ;
  logic              swRstQ;
  logic [DATA_W-1:0] shadowQ;
  rate_e             mfmD, fmD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ      <= RESET_SEL;
      pcQ       <= '0;
      lowPowerQ <= 1'b0;
      swRstQ    <= 1'b0;
      shadowQ   <= RESET_VAL;
    end else begin
      swRstQ <= strobe.swReset;
      if (strobe.load) begin
        selQ    <= wrData[SEL_LO +: 2];
        pcQ     <= wrData[PC_LO +: PC_W];
        shadowQ <= wrData & ZERO_MASK;
      end
      if (strobe.enterLp)     lowPowerQ <= 1'b1;
      else if (strobe.exitLp) lowPowerQ <= 1'b0;
    end
  end

  always_comb begin
    mfmD = RATE_250K;
    fmD  = RATE_125K;
    unique case (selQ)
      2'b11: begin mfmD = RATE_1M;   fmD = RATE_NONE; end
      2'b00: begin mfmD = RATE_500K; fmD = RATE_250K; end
      2'b10: begin mfmD = RATE_250K; fmD = RATE_125K; end
      2'b01: begin
        unique case (driveType)
          2'b01:   begin mfmD = RATE_500K; fmD = RATE_250K; end
          2'b10:   begin mfmD = RATE_2M;   fmD = RATE_NONE; end
          default: begin mfmD = RATE_300K; fmD = RATE_150K; end
        endcase
      end
      default: ;
    endcase
  end

  assign mfmRate       = mfmD;
  assign fmRate        = fmD;
  assign densel        = (selQ == 2'b11) || (selQ == 2'b00);
  assign precompSel    = pcQ;
  assign clkEnable     = !lowPowerQ;
  assign ctlResetPulse = swRstQ;
  assign regRdData     = {swRstQ, lowPowerQ, 1'b0, pcQ, selQ};
  assign rtData        = (rtAddr == SHADOW_OFS) ? shadowQ : '0;
endmodule

// File: rtl/fdc_rate_top.sv
module fdc_rate_top
  import fdc_rate_pkg::*;
#(
  parameter int RT_ADDR_W = 5,
  parameter logic [RT_ADDR_W-1:0] SHADOW_OFS = 5'h1F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [7:0]           wrData,
  output logic [7:0]           regRdData,
  input  logic                 dataAccess,
  input  logic                 statusAccess,
  input  logic [1:0]           driveType,
  input  logic [RT_ADDR_W-1:0] rtAddr,
  output logic [7:0]           rtData,
  output logic [2:0]           mfmRate,
  output logic [2:0]           fmRate,
  output logic                 densel,
  output logic [2:0]           precompSel,
  output logic                 clkEnable,
  output logic                 ctlResetPulse
);
  ctl_strobe_t strobe;
  logic        lowPowerQ;

  fdc_rate_ctrl uCtrl (
    .wrEn(wrEn), .wrData(wrData), .dataAccess(dataAccess),
    .statusAccess(statusAccess), .lowPowerQ(lowPowerQ), .strobe(strobe)
  );

  fdc_rate_dp #(.RT_ADDR_W(RT_ADDR_W), .SHADOW_OFS(SHADOW_OFS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .driveType(driveType), .rtAddr(rtAddr), .lowPowerQ(lowPowerQ),
    .regRdData(regRdData), .rtData(rtData), .mfmRate(mfmRate),
    .fmRate(fmRate), .densel(densel), .precompSel(precompSel),
    .clkEnable(clkEnable), .ctlResetPulse(ctlResetPulse)
  );
endmodule

// File: rtl/fdc_rate_checker.sv
module fdc_rate_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] regRdData,
  input logic       dataAccess,
  input logic       statusAccess,
  input logic       clkEnable,
  input logic       ctlResetPulse,
  input logic [2:0] precompSel
);
  assert_fields_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (precompSel == $past(wrData[4:2])) && (regRdData[1:0] == $past(wrData[1:0])));

  assert_enter_lp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[6] && !wrData[7]) |=> !clkEnable);

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnable && (dataAccess || statusAccess) && !wrEn) |=> clkEnable);

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[7]) |=> (ctlResetPulse && clkEnable));

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlResetPulse && !(wrEn && wrData[7])) |=> !ctlResetPulse);

  assert_pulse_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlResetPulse) |-> $past(wrEn && wrData[7]));
endmodule

bind fdc_rate_top fdc_rate_checker uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .regRdData(regRdData),
  .dataAccess(dataAccess), .statusAccess(statusAccess), .clkEnable(clkEnable),
  .ctlResetPulse(ctlResetPulse), .precompSel(precompSel)
);

// File: tb/tb_fdc_rate_top.sv
module tb_fdc_rate_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] regRdData;
  logic       dataAccess = 1'b0;
  logic       statusAccess = 1'b0;
  logic [1:0] driveType = 2'b00;
  logic [4:0] rtAddr = '0;
  logic [7:0] rtData;
  logic [2:0] mfmRate, fmRate, precompSel;
  logic       densel, clkEnable, ctlResetPulse;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  fdc_rate_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .regRdData(regRdData),
    .dataAccess(dataAccess), .statusAccess(statusAccess), .driveType(driveType),
    .rtAddr(rtAddr), .rtData(rtData), .mfmRate(mfmRate), .fmRate(fmRate),
    .densel(densel), .precompSel(precompSel), .clkEnable(clkEnable),
    .ctlResetPulse(ctlResetPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one-cycle write; returns at the falling edge after the capturing edge
  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseAccess(input bit useStatus);
    @(negedge clk); dataAccess = !useStatus; statusAccess = useStatus;
    @(negedge clk); dataAccess = 1'b0; statusAccess = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 regRdData", regRdData, 8'h02);
    chk("R1 clkEnable", clkEnable, 1);
    chk("R1 ctlResetPulse", ctlResetPulse, 0);
    chk("R1 mfmRate", mfmRate, 3);
    chk("R1 precompSel", precompSel, 0);
  endtask

  task automatic testFields();
    doWrite(8'b000_101_01);
    chk("R2 precompSel", precompSel, 3'b101);
    chk("R2 regRdData", regRdData, 8'h15);
    doWrite(8'b000_010_11);
    chk("R2 precompSel second", precompSel, 3'b010);
    chk("R2 regRdData second", regRdData, 8'h0B);
  endtask

  task automatic testBit5();
    doWrite(8'h3F);
    chk("R3 bit5 read", regRdData[5], 0);
    chk("R3 regRdData", regRdData, 8'h1F);
  endtask

  task automatic testLowPower();
    doWrite(8'h40);
    chk("R4 clkEnable", clkEnable, 0);
    chk("R4 bit6 read", regRdData[6], 1);
    pulseAccess(1'b0);
    chk("R5 wake by data access", clkEnable, 1);
    doWrite(8'h40);
    chk("R4 re-enter", clkEnable, 0);
    pulseAccess(1'b1);
    chk("R5 wake by status access", clkEnable, 1);
    doWrite(8'h40);
    @(negedge clk); wrEn = 1'b1; wrData = 8'h40; dataAccess = 1'b1;
    @(negedge clk); wrEn = 1'b0; wrData = '0; dataAccess = 1'b0;
    chk("R5 write wins over access", clkEnable, 0);
    @(negedge clk);
    chk("R5 no wake without access", clkEnable, 0);
  endtask

  task automatic testSwReset();
    // still in low power from the previous scenario
    doWrite(8'hC2);
    chk("R6 pulse high", ctlResetPulse, 1);
    chk("R6 bit7 reads 1", regRdData[7], 1);
    chk("R6 low power cleared", clkEnable, 1);
    @(negedge clk);
    chk("R6 pulse one cycle", ctlResetPulse, 0);
    chk("R6 bit7 self-clears", regRdData[7], 0);
    chk("R6 register after", regRdData, 8'h02);
  endtask

  task automatic checkRate(input logic [1:0] dt, input logic [1:0] sel,
                           input int expM, input int expF, input string req);
    driveType = dt;
    doWrite({6'b0, sel});
    chk({req, " mfmRate"}, mfmRate, expM);
    chk({req, " fmRate"}, fmRate, expF);
  endtask

  task automatic testDecodeBase();
    for (int t = 0; t < 4; t += 3) begin
      checkRate(2'(t), 2'b11, 6, 0, "R7 sel11");
      checkRate(2'(t), 2'b00, 5, 3, "R7 sel00");
      checkRate(2'(t), 2'b01, 4, 2, "R7 sel01");
      checkRate(2'(t), 2'b10, 3, 1, "R7 sel10");
    end
  endtask

  task automatic testDecodeTypes();
    checkRate(2'b01, 2'b01, 5, 3, "R8 type01 sel01");
    checkRate(2'b10, 2'b01, 7, 0, "R8 type10 sel01");
    checkRate(2'b01, 2'b11, 6, 0, "R8 type01 sel11");
    checkRate(2'b10, 2'b00, 5, 3, "R8 type10 sel00");
    checkRate(2'b10, 2'b10, 3, 1, "R8 type10 sel10");
    driveType = 2'b00;
  endtask

  task automatic testDensity();
    doWrite(8'h03); chk("R9 densel sel11", densel, 1);
    doWrite(8'h00); chk("R9 densel sel00", densel, 1);
    doWrite(8'h01); chk("R9 densel sel01", densel, 0);
    doWrite(8'h02); chk("R9 densel sel10", densel, 0);
  endtask

  task automatic testShadow();
    doWrite(8'hB5);
    rtAddr = 5'h1F;
    @(negedge clk);
    chk("R10 shadow holds bit7, masks bit5", rtData, 8'h95);
    rtAddr = 5'h1E;
    #1 chk("R10 other address reads 0", rtData, 0);
    rtAddr = 5'h1F;
    doWrite(8'h24);
    chk("R10 shadow updates", rtData, 8'h04);
  endtask

  task automatic testShadowReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rtAddr = 5'h1F;
    #1 chk("R10 shadow after reset", rtData, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFields();
    testBit5();
    testLowPower();
    testSwReset();
    testDecodeBase();
    testDecodeTypes();
    testDensity();
    testShadow();
    testShadowReset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule